// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs entry into a handler for a pipelined 32-bit core. Interrupts, exceptions and traps all share it. When the core raises a request, the sequencer captures several values: the 8-bit event number, the PC and status word to resume from, the table base and the system stack pointer. It then stops instruction fetch and cancels the younger instructions already in the pipe. After that it performs four steps in a fixed order.

The four steps are:
1. Read the handler address from the vector table.
2. Store the status word on the stack.
3. Store the resume PC on the stack.
4. Look again at the request line.

If another event is waiting at step 4, the whole sequence starts over without running any handler instruction. In the second pass the saved PC is the first handler's address. If no event is waiting, the sequencer pulses a completion flag and lets fetch restart at the new PC.

All memory traffic goes through one request/acknowledge port. Each step waits there for as many cycles as memory needs.

Top module: `exc_entry_seq`

## Requirements
- R1: After a synchronous active-high reset, the following outputs are low: `fetch_stall`, `kill`, `pc_load`, `done` and `mem_valid`.
- R2: A request accepted while idle gives exactly one `kill` pulse, in the cycle after the accepting edge. `fetch_stall` is high from that cycle until the sequence ends.
- R3: The first memory access is a read (`mem_we`=0) at word address `tbr + 0x3FC - 4*vector`.
- R4: The read data appears on `new_pc`, with a one-cycle `pc_load` pulse, in the cycle after the read handshake.
- R5: The second access writes the captured status word to `ssp-4`. The third access writes the resume PC to `ssp-8`. The status word is always stored before the PC.
- R6: After each store handshake, `ssp_out` equals the address just written. The stack pointer after one full pass is `ssp-8`.
- R7: While `mem_valid` is high and `mem_ready` is low, the request (valid, write enable, address, data) is held unchanged.
- R8: If `evt_req` is high at the check step, the sequence restarts at the vector read using the new vector and the live `tbr`. It saves the live `cur_ps` and the earlier handler address as the resume PC. It keeps decrementing from the current stack pointer, and it raises no `done` and no extra `kill` between the passes.
- R9: When no event is pending at the check step, `done` pulses for one cycle and `fetch_stall` is low in that same cycle.
- R10: Changes to `evt_req`, `evt_vec`, `cur_pc`, `cur_ps`, `tbr` and `ssp_in` during the read and store steps do not affect the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_req | input | 1 | Event pending |
| evt_vec | input | 8 | Event number |
| cur_pc | input | 32 | PC to resume from |
| cur_ps | input | 32 | Status word to save |
| tbr | input | 32 | Vector table base |
| ssp_in | input | 32 | System stack pointer at entry |
| mem_valid | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts/completes request |
| mem_rdata | input | 32 | Read data |
| new_pc | output | 32 | Handler address |
| pc_load | output | 1 | One-cycle strobe: load `new_pc` |
| ssp_out | output | 32 | Current stack pointer |
| fetch_stall | output | 1 | Fetch held while sequencing |
| kill | output | 1 | Cancel younger in-flight instructions |
| done | output | 1 | Sequence finished |

## Verification
The hardest case to reach from the ports is the restart at the check step. For it, `evt_req` must be high in exactly the one cycle in which the stores are complete, and low again before the second check. The stimulus raises the request and keeps it high through the first pass, relying on R10 so that the request is ignored until the check step. It drops the request once the memory model has acknowledged the second vector read, so the second pass ends normally. A second scenario toggles every input during a long memory wait. The memory model inserts a varying number of wait states before each acknowledge.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_VEC  = 3'd1,
        ST_PS   = 3'd2,
        ST_PC   = 3'd3,
        ST_CHK  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned VEC_W = 8
) (
    input  logic [XLEN-1:0]  tbr,
    input  logic [VEC_W-1:0] vec,
    output logic [XLEN-1:0]  addr
);
    // highest table entry sits at base + (entries-1)*4; entry n counts down from it
    localparam int unsigned TOP_OFS = ((2 ** VEC_W) - 1) * 4;

    logic [XLEN-1:0] scaled;

    always_comb begin
        scaled = XLEN'({vec, 2'b00});
        addr   = tbr + XLEN'(TOP_OFS) - scaled;
    end
endmodule

// File: rtl/exc_mem_req.sv
module exc_mem_req
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  seq_state_e      st,
    input  logic [XLEN-1:0] vec_addr,
    input  logic [XLEN-1:0] ssp,
    input  logic [XLEN-1:0] ps_sv,
    input  logic [XLEN-1:0] pc_sv,
    output logic            valid,
    output logic            we,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] wdata
);
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    always_comb begin
        valid = 1'b0;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        unique case (st)
            ST_VEC: begin
                valid = 1'b1;
                addr  = vec_addr;
            end
            ST_PS: begin
                valid = 1'b1;
                we    = 1'b1;
                addr  = ssp - WORD;
                wdata = ps_sv;
            end
            ST_PC: begin
                valid = 1'b1;
                we    = 1'b1;
                addr  = ssp - WORD;
                wdata = pc_sv;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_req,
    input  logic [VEC_W-1:0] evt_vec,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_ps,
    input  logic [XLEN-1:0]  tbr,
    input  logic [XLEN-1:0]  ssp_in,
    output logic             mem_valid,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ready,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [XLEN-1:0]  new_pc,
    output logic             pc_load,
    output logic [XLEN-1:0]  ssp_out,
    output logic             fetch_stall,
    output logic             kill,
    output logic             done
);
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    typedef struct packed {
        seq_state_e       st;
        logic [VEC_W-1:0] vec;
        logic [XLEN-1:0]  tbr;
        logic [XLEN-1:0]  ssp;
        logic [XLEN-1:0]  pc_sv;
        logic [XLEN-1:0]  ps_sv;
        logic [XLEN-1:0]  hpc;
        logic             pc_load;
        logic             kill;
        logic             done;
    } seq_regs_t;

    seq_regs_t       r_d, r_q;
    logic [XLEN-1:0] vec_addr;
    logic            hs;

    exc_vec_addr #(.XLEN(XLEN), .VEC_W(VEC_W)) i_vec_addr (
        .tbr  (r_q.tbr),
        .vec  (r_q.vec),
        .addr (vec_addr)
    );

    exc_mem_req #(.XLEN(XLEN)) i_mem_req (
        .st       (r_q.st),
        .vec_addr (vec_addr),
        .ssp      (r_q.ssp),
        .ps_sv    (r_q.ps_sv),
        .pc_sv    (r_q.pc_sv),
        .valid    (mem_valid),
        .we       (mem_we),
        .addr     (mem_addr),
        .wdata    (mem_wdata)
    );

    assign hs = mem_valid && mem_ready;

    always_comb begin
        r_d         = r_q;
        r_d.pc_load = 1'b0;
        r_d.kill    = 1'b0;
        r_d.done    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (evt_req) begin
                    r_d.st    = ST_VEC;
                    r_d.vec   = evt_vec;
                    r_d.tbr   = tbr;
                    r_d.ssp   = ssp_in;
                    r_d.pc_sv = cur_pc;
                    r_d.ps_sv = cur_ps;
                    r_d.kill  = 1'b1;
                end
            end
            ST_VEC: begin
                if (hs) begin
                    r_d.hpc     = mem_rdata;
                    r_d.pc_load = 1'b1;
                    r_d.st      = ST_PS;
                end
            end
            ST_PS: begin
                if (hs) begin
                    r_d.ssp = r_q.ssp - WORD;
                    r_d.st  = ST_PC;
                end
            end
            ST_PC: begin
                if (hs) begin
                    r_d.ssp = r_q.ssp - WORD;
                    r_d.st  = ST_CHK;
                end
            end
            ST_CHK: begin
                if (evt_req) begin
                    // nested entry: handler never ran, so its address is the resume point
                    r_d.st    = ST_VEC;
                    r_d.vec   = evt_vec;
                    r_d.tbr   = tbr;
                    r_d.pc_sv = r_q.hpc;
                    r_d.ps_sv = cur_ps;
                end else begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign new_pc      = r_q.hpc;
    assign pc_load     = r_q.pc_load;
    assign ssp_out     = r_q.ssp;
    assign fetch_stall = (r_q.st != ST_IDLE);
    assign kill        = r_q.kill;
    assign done        = r_q.done;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            mem_valid,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_ready,
    input logic            pc_load,
    input logic [XLEN-1:0] ssp_out,
    input logic            fetch_stall,
    input logic            kill,
    input logic            done
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!fetch_stall && !kill && !pc_load && !done && !mem_valid));

    // R2
    kill_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
        kill |-> fetch_stall);

    // R4
    load_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> $past(mem_valid && mem_ready && !mem_we));

    // R6
    ssp_tracks_store_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_we) |=> (ssp_out == $past(mem_addr)));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R9
    done_released_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!fetch_stall && !kill));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) i_exc_entry_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_valid   (mem_valid),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .pc_load     (pc_load),
    .ssp_out     (ssp_out),
    .fetch_stall (fetch_stall),
    .kill        (kill),
    .done        (done)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_req = 1'b0;
    logic [7:0]  evt_vec = '0;
    logic [31:0] cur_pc = '0, cur_ps = '0, tbr = '0, ssp_in = '0;
    logic        mem_valid, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] new_pc, ssp_out;
    logic        pc_load, fetch_stall, kill, done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst(rst), .evt_req(evt_req), .evt_vec(evt_vec),
        .cur_pc(cur_pc), .cur_ps(cur_ps), .tbr(tbr), .ssp_in(ssp_in),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .new_pc(new_pc), .pc_load(pc_load), .ssp_out(ssp_out),
        .fetch_stall(fetch_stall), .kill(kill), .done(done)
    );

    // memory model: fixed wait states, logs each accepted request
    int          lat = 0;
    int          wcnt = 0;
    int          tr_n = 0;
    logic        tr_we [8];
    logic [31:0] tr_addr [8];
    logic [31:0] tr_data [8];
    int          n_kill = 0, n_done = 0, n_load = 0;

    function automatic logic [31:0] table_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    function automatic logic [31:0] vaddr(input logic [31:0] base, input logic [7:0] v);
        return base + 32'h3FC - {22'd0, v, 2'b00};
    endfunction

    always @(negedge clk) begin
        if (mem_valid && !mem_ready) begin
            if (wcnt >= lat) begin
                mem_ready <= 1'b1;
                mem_rdata <= table_word(mem_addr);
                if (tr_n < 8) begin
                    tr_we[tr_n]   <= mem_we;
                    tr_addr[tr_n] <= mem_addr;
                    tr_data[tr_n] <= mem_wdata;
                end
                tr_n <= tr_n + 1;
                wcnt <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
            wcnt      <= 0;
        end
        if (kill)    n_kill <= n_kill + 1;
        if (done)    n_done <= n_done + 1;
        if (pc_load) n_load <= n_load + 1;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        tr_n = 0; n_kill = 0; n_done = 0; n_load = 0;
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (!done && k < 500) begin
            @(negedge clk);
            k++;
        end
        check("R9", "done seen", {31'd0, done}, 32'd1);
        check("R9", "fetch_stall at done", {31'd0, fetch_stall}, 32'd0);
        @(negedge clk);
        check("R9", "done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic check_pass(input int base, input logic [31:0] va,
                              input logic [31:0] sp, input logic [31:0] ps,
                              input logic [31:0] pc);
        check("R3", "read is read", {31'd0, tr_we[base]}, 32'd0);
        check("R3", "vector address", tr_addr[base], va);
        check("R5", "PS store is write", {31'd0, tr_we[base+1]}, 32'd1);
        check("R5", "PS store addr", tr_addr[base+1], sp - 32'd4);
        check("R5", "PS store data", tr_data[base+1], ps);
        check("R5", "PC store is write", {31'd0, tr_we[base+2]}, 32'd1);
        check("R5", "PC store addr", tr_addr[base+2], sp - 32'd8);
        check("R5", "PC store data", tr_data[base+2], pc);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "fetch_stall", {31'd0, fetch_stall}, 32'd0);
        check("R1", "kill", {31'd0, kill}, 32'd0);
        check("R1", "pc_load", {31'd0, pc_load}, 32'd0);
        check("R1", "done", {31'd0, done}, 32'd0);
        check("R1", "mem_valid", {31'd0, mem_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_single(input logic [7:0] v, input logic [31:0] t,
                            input logic [31:0] sp, input int l);
        logic [31:0] pc, ps, va;
        pc = 32'h0040_1230 + {24'd0, v};
        ps = 32'h0000_F0C0 ^ {24'd0, v};
        va = vaddr(t, v);
        lat = l;
        clear_log();
        evt_vec = v; cur_pc = pc; cur_ps = ps; tbr = t; ssp_in = sp;
        evt_req = 1'b1;
        @(negedge clk);
        evt_req = 1'b0;
        check("R2", "kill after accept", {31'd0, kill}, 32'd1);
        check("R2", "fetch_stall after accept", {31'd0, fetch_stall}, 32'd1);
        wait_done();
        check("R5", "access count", tr_n, 32'd3);
        check_pass(0, va, sp, ps, pc);
        check("R4", "new_pc", new_pc, table_word(va));
        check("R4", "pc_load count", n_load, 32'd1);
        check("R6", "final ssp", ssp_out, sp - 32'd8);
        check("R2", "kill count", n_kill, 32'd1);
    endtask

    task automatic t_ignore();
        logic [31:0] va;
        va = vaddr(32'h1000_0000, 8'h21);
        lat = 4;
        clear_log();
        evt_vec = 8'h21; cur_pc = 32'hAAAA_0000; cur_ps = 32'h0000_0055;
        tbr = 32'h1000_0000; ssp_in = 32'h2000_0100;
        evt_req = 1'b1;
        @(negedge clk);
        // R10: scramble every input and pulse the request during the read wait
        evt_req = 1'b0;
        evt_vec = 8'h99; cur_pc = 32'h1111_1111; cur_ps = 32'h2222_2222;
        tbr = 32'h3333_0000; ssp_in = 32'h4444_0000;
        @(negedge clk);
        evt_req = 1'b1;
        @(negedge clk);
        evt_req = 1'b0;
        wait_done();
        check("R10", "access count", tr_n, 32'd3);
        check_pass(0, va, 32'h2000_0100, 32'h0000_0055, 32'hAAAA_0000);
        check("R10", "kill count", n_kill, 32'd1);
        check("R10", "final ssp", ssp_out, 32'h2000_00F8);
    endtask

    task automatic t_restart();
        logic [31:0] va1, va2, sp;
        int k;
        sp  = 32'h3000_0040;
        va1 = vaddr(32'h0800_0000, 8'h05);
        va2 = vaddr(32'h0900_0000, 8'h40);
        lat = 1;
        clear_log();
        evt_vec = 8'h05; cur_pc = 32'h0000_7770; cur_ps = 32'h0000_0011;
        tbr = 32'h0800_0000; ssp_in = sp;
        evt_req = 1'b1;
        @(negedge clk);
        // request stays high; only the check step may take it (R8)
        evt_vec = 8'h40; cur_ps = 32'h0000_0022; tbr = 32'h0900_0000;
        k = 0;
        while (tr_n < 4 && k < 200) begin
            @(negedge clk);
            k++;
        end
        evt_req = 1'b0;
        wait_done();
        check("R8", "access count", tr_n, 32'd6);
        check_pass(0, va1, sp, 32'h0000_0011, 32'h0000_7770);
        check_pass(3, va2, sp - 32'd8, 32'h0000_0022, table_word(va1));
        check("R8", "done count", n_done, 32'd1);
        check("R8", "kill count", n_kill, 32'd1);
        check("R8", "pc_load count", n_load, 32'd2);
        check("R8", "new_pc", new_pc, table_word(va2));
        check("R8", "final ssp", ssp_out, sp - 32'd16);
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_single(8'h00, 32'h0000_0000, 32'h0001_0000, 0);
        t_single(8'hFF, 32'h00FF_F000, 32'h0002_0000, 3);
        t_single(8'h0E, 32'h1234_5000, 32'h0000_0008, 1);
        t_ignore();
        t_restart();
        t_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule